// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Aliases

This block is one 16-pin general-purpose I/O port. Software reaches it through a plain synchronous register bus that has an address, a write strobe, a read strobe and a data word. The port keeps six control registers: pin direction, output latch, open-drain select, digital-enable for pins that can be analog, pull-up enable and change-notification enable. It turns them into per-pin output-enable and output-data signals, and it reports the synchronized pin levels back to software.

Each register group takes four word addresses: the base, a clear alias, a set alias and an invert alias. A write to an alias acts only on the bits written as 1. Software can therefore flip or force single pins with one bus write and no read-modify-write. Writes to the pin-data group go to the output latch. A sticky interrupt goes high when a pin that has notification enabled differs from the value software saw at its last pin-data read. That read also clears the interrupt.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset, every implemented direction bit is 1 (all pins are inputs). Every other register is 0, `pinOe` is 0 and `irq` is 0.
- R2: A write to a base address stores the data. A later read of that base address returns it in `rdData` one cycle after `rdEn`. Bits of pins outside `IMPL_MASK` read as 0. Group offsets: direction 0x00, latch 0x10, pin-data 0x20, open-drain 0x30, digital-enable 0x40, pull-up 0x50, change-enable 0x60.
- R3: Writes to base+0x4 clear, base+0x8 set and base+0xC invert only the register bits that are 1 in `wrData`. All other bits keep their value.
- R4: A read of any alias address, an undefined group or an address that is not word aligned returns 0. A write to an undefined group or to an unaligned address changes no register.
- R5: A write to the pin-data group (base or alias) acts on the output latch. A read of the latch returns the last value written there through either group.
- R6: A read of the pin-data base returns `pinIn` as it was two clock edges earlier. Implemented pins only are reported. A pin in `ANALOG_CAP` whose digital-enable bit is 0 reads 0.
- R7: An implemented pin drives (`pinOe`=1) only when its direction bit is 0. If its open-drain bit is also 1, it drives only while its latch bit is 0. `pinOut` equals the latch bit, forced to 0 for open-drain pins.
- R8: `irq` goes high and stays high once a pin with its change-enable bit at 1 has a synchronized level that differs from the level captured at the last pin-data base read. A pin-data base read clears `irq` and takes a new capture.
- R9: `pullUpEn` shows the pull-up register for implemented pins and is 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the register |
| wrData | input | 16 | Write data or alias bit mask |
| rdData | output | 16 | Read data, valid the cycle after rdEn |
| pinIn | input | 16 | Raw pin levels (asynchronous) |
| pinOe | output | 16 | Per-pin output enable |
| pinOut | output | 16 | Per-pin output level |
| pullUpEn | output | 16 | Per-pin pull-up control |
| irq | output | 1 | Sticky change-notification request |

## Verification
The assertions check on every cycle that:
- no pin drives while it is an input or unimplemented;
- an open-drain output with a high latch bit is released;
- pull-up controls never reach missing pins;
- alias reads return zero;
- a pin-data read always leaves the interrupt low on the next cycle;
- the direction register holds its reset state on the first edge after reset.

Only the bench scenarios can show the value effects that depend on history. These are the clear, set and invert arithmetic, the redirection of pin-data writes into the latch, the two-cycle input delay with analog masking, and whether a change on an enabled pin raises the interrupt while a change on a disabled pin does not.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } aliasOpT;

  localparam int NUM_REGS = 6;
  localparam int REG_DIR  = 0;
  localparam int REG_LAT  = 1;
  localparam int REG_OD   = 2;
  localparam int REG_DIG  = 3;
  localparam int REG_PU   = 4;
  localparam int REG_CN   = 5;

  localparam logic [2:0] GRP_DIR = 3'd0;
  localparam logic [2:0] GRP_LAT = 3'd1;
  localparam logic [2:0] GRP_PIN = 3'd2;
  localparam logic [2:0] GRP_OD  = 3'd3;
  localparam logic [2:0] GRP_DIG = 3'd4;
  localparam logic [2:0] GRP_PU  = 3'd5;
  localparam logic [2:0] GRP_CN  = 3'd6;
  localparam int NUM_GRPS = 7;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    aliasOpT             op;
    logic                rdStrobe;
    logic                rdValid;
    logic                rdPin;
    logic [2:0]          rdGrp;
  } ctrlT;

endpackage

// File: rtl/gpio_alias_ctrl.sv
module gpio_alias_ctrl
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlT              ctrl
);
  localparam int GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grpField;
  logic [1:0]       subField;
  logic             aligned;
  logic             known;
  logic [2:0]       grpCode;

  assign grpField = addr[ADDR_W-1:4];
  assign subField = addr[3:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign known    = (grpField < GRP_W'(NUM_GRPS));
  assign grpCode  = grpField[2:0];

  always_comb begin
    ctrl    = '0;
    ctrl.op = aliasOpT'(subField);
    if (wrEn && aligned && known) begin
      case (grpCode)
        GRP_DIR:          ctrl.wrSel[REG_DIR] = 1'b1;
        GRP_LAT, GRP_PIN: ctrl.wrSel[REG_LAT] = 1'b1;
        GRP_OD:           ctrl.wrSel[REG_OD]  = 1'b1;
        GRP_DIG:          ctrl.wrSel[REG_DIG] = 1'b1;
        GRP_PU:           ctrl.wrSel[REG_PU]  = 1'b1;
        GRP_CN:           ctrl.wrSel[REG_CN]  = 1'b1;
        default:          ctrl.wrSel          = '0;
      endcase
    end
    if (rdEn) begin
      ctrl.rdStrobe = 1'b1;
      if (aligned && known && subField == 2'b00) begin
        ctrl.rdValid = 1'b1;
        ctrl.rdGrp   = grpCode;
        ctrl.rdPin   = (grpCode == GRP_PIN);
      end
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_alias_dp.sv
module gpio_alias_dp
  import gpio_alias_pkg::*;
#(
  parameter int               WIDTH      = 16,
  parameter logic [WIDTH-1:0] IMPL_MASK  = '1,
  parameter logic [WIDTH-1:0] ANALOG_CAP = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlT             ctrl,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] syncIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] dirBits,
  output logic [WIDTH-1:0] latBits,
  output logic [WIDTH-1:0] odBits,
  output logic [WIDTH-1:0] puBits,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic             irq
);
  logic [WIDTH-1:0] regQ [NUM_REGS];
  logic [WIDTH-1:0] pinVal;
  logic [WIDTH-1:0] readMux;
  logic [WIDTH-1:0] snapQ;
  logic             changeHit;

  function automatic logic [WIDTH-1:0] applyOp(
    input aliasOpT op, input logic [WIDTH-1:0] cur, input logic [WIDTH-1:0] d);
    case (op)
      OP_CLR:  applyOp = cur & ~d;
      OP_SET:  applyOp = cur | d;
      OP_INV:  applyOp = cur ^ d;
      default: applyOp = d;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [WIDTH-1:0] RESET_VAL = (g == REG_DIR) ? IMPL_MASK : '0;
    always_ff @(posedge clk) begin
      if (!rstN)
        regQ[g] <= RESET_VAL;
      else if (ctrl.wrSel[g])
        regQ[g] <= applyOp(ctrl.op, regQ[g], wrData) & IMPL_MASK;
    end
  end

  assign dirBits = regQ[REG_DIR];
  assign latBits = regQ[REG_LAT];
  assign odBits  = regQ[REG_OD];
  assign puBits  = regQ[REG_PU];

  assign pinVal  = syncIn & (regQ[REG_DIG] | ~ANALOG_CAP) & IMPL_MASK;
  assign pinOe   = IMPL_MASK & ~regQ[REG_DIR] & ~(regQ[REG_OD] & regQ[REG_LAT]);
  assign pinOut  = regQ[REG_LAT] & ~regQ[REG_OD];

  always_comb begin
    readMux = '0;
    if (ctrl.rdValid) begin
      case (ctrl.rdGrp)
        GRP_DIR: readMux = regQ[REG_DIR];
        GRP_LAT: readMux = regQ[REG_LAT];
        GRP_PIN: readMux = pinVal;
        GRP_OD:  readMux = regQ[REG_OD];
        GRP_DIG: readMux = regQ[REG_DIG];
        GRP_PU:  readMux = regQ[REG_PU];
        GRP_CN:  readMux = regQ[REG_CN];
        default: readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (ctrl.rdStrobe) rdData <= readMux;
  end

  assign changeHit = |((pinVal ^ snapQ) & regQ[REG_CN]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapQ <= '0;
      irq   <= 1'b0;
    end else if (ctrl.rdPin) begin
      snapQ <= pinVal;
      irq   <= 1'b0;
    end else if (changeHit) begin
      irq   <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int               WIDTH      = 16,
  parameter int               ADDR_W     = 8,
  parameter int               SYNC_DEPTH = 2,
  parameter logic [WIDTH-1:0] IMPL_MASK  = 16'h7FFF,
  parameter logic [WIDTH-1:0] ANALOG_CAP = 16'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pullUpEn,
  output logic              irq
);
  ctrlT             ctrl;
  logic [WIDTH-1:0] syncIn;
  logic [WIDTH-1:0] dirBits;
  logic [WIDTH-1:0] latBits;
  logic [WIDTH-1:0] odBits;

  gpio_alias_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .ctrl(ctrl)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncIn)
  );

  gpio_alias_dp #(
    .WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK), .ANALOG_CAP(ANALOG_CAP)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .syncIn(syncIn),
    .rdData(rdData), .dirBits(dirBits), .latBits(latBits), .odBits(odBits),
    .puBits(pullUpEn), .pinOe(pinOe), .pinOut(pinOut), .irq(irq)
  );
endmodule

// File: rtl/gpio_alias_port_checker.sv
module gpio_alias_port_checker #(
  parameter int               WIDTH     = 16,
  parameter int               ADDR_W    = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  pullUpEn,
  input logic              irq,
  input logic [WIDTH-1:0]  dirBits,
  input logic [WIDTH-1:0]  odBits,
  input logic [WIDTH-1:0]  latBits
);
  localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(8'h20);

  assert_reset_dir_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dirBits == IMPL_MASK));

  assert_oe_needs_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & (dirBits | ~IMPL_MASK)) == '0);

  assert_od_release_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & odBits & latBits) == '0);

  assert_alias_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[3:2] != 2'b00) |=> (rdData == '0));

  assert_pin_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == PIN_ADDR) |=> !irq);

  assert_pullup_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pullUpEn & ~IMPL_MASK) == '0);
endmodule

bind gpio_alias_port gpio_alias_port_checker #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .rdData(rdData),
  .pinOe(pinOe), .pullUpEn(pullUpEn), .irq(irq),
  .dirBits(dirBits), .odBits(odBits), .latBits(latBits)
);

// File: tb/gpio_alias_port_test.sv
module gpio_alias_port_test;
  localparam logic [15:0] IMPL = 16'h7FFF;
  localparam logic [15:0] ACAP = 16'h00FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] pinIn = '0;
  logic [15:0] rdData, pinOe, pinOut, pullUpEn;
  logic        irq;

  always #4 clk = ~clk;

  gpio_alias_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOe(pinOe),
    .pinOut(pinOut), .pullUpEn(pullUpEn), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit modelLive = 0;

  // Behavioural reference model: register file indexed by group, FIFO for input delay
  logic [15:0] mReg [7];
  logic [15:0] mRd, mSnap;
  logic        mIrq;
  logic [15:0] delayQ [$];

  function automatic logic [15:0] mPinVal();
    return delayQ[0] & (mReg[4] | ~ACAP) & IMPL;
  endfunction

  always @(posedge clk) begin
    logic [15:0] pv;
    if (!rstN) begin
      for (int i = 0; i < 7; i++) mReg[i] = 16'h0;
      mReg[0] = IMPL;
      mRd = 0; mSnap = 0; mIrq = 0;
      delayQ = {16'h0, 16'h0};
    end else begin
      pv = mPinVal();
      if (rdEn) begin
        if (addr[1:0] == 0 && addr[3:2] == 0 && addr[7:4] < 7 && addr[7:4] != 2)
          mRd = mReg[addr[7:4]];
        else if (addr == 8'h20)
          mRd = pv;
        else
          mRd = 0;
      end
      if (rdEn && addr == 8'h20) begin
        mSnap = pv; mIrq = 0;
      end else if (((pv ^ mSnap) & mReg[6]) != 0) begin
        mIrq = 1;
      end
      if (wrEn && addr[1:0] == 0 && addr[7:4] < 7) begin
        int g;
        g = (addr[7:4] == 2) ? 1 : int'(addr[7:4]);
        case (addr[3:2])
          2'd0: mReg[g] = wrData;
          2'd1: mReg[g] = mReg[g] & ~wrData;
          2'd2: mReg[g] = mReg[g] | wrData;
          default: mReg[g] = mReg[g] ^ wrData;
        endcase
        mReg[g] = mReg[g] & IMPL;
      end
      void'(delayQ.pop_front());
      delayQ.push_back(pinIn);
    end
  end

  task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelLive) begin
      cmp("rdData", rdData, mRd);
      cmp("pinOe", pinOe, IMPL & ~mReg[0] & ~(mReg[3] & mReg[1]));
      cmp("pinOut", pinOut, mReg[1] & ~mReg[3]);
      cmp("pullUpEn", pullUpEn, mReg[5]);
      cmp("irq", {15'h0, irq}, {15'h0, mIrq});
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [15:0] exp);
    @(negedge clk); rdEn = 1; addr = a;
    @(negedge clk); rdEn = 0;
    cmp($sformatf("read %h", a), rdData, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    modelLive = 1;
    curReq = "R1";
    cmp("pinOe at reset", pinOe, 16'h0);
    cmp("irq at reset", {15'h0, irq}, 16'h0);
    rd(8'h00, 16'h7FFF);
    rd(8'h10, 16'h0000);

    curReq = "R2";
    wr(8'h00, 16'h0000);
    rd(8'h00, 16'h0000);
    wr(8'h10, 16'hA5A5);
    rd(8'h10, 16'h25A5);
    cmp("pinOut push-pull", pinOut, 16'h25A5);

    curReq = "R7";
    wr(8'h30, 16'h00FF);
    cmp("pinOe open-drain", pinOe, 16'h7F5A);
    cmp("pinOut open-drain", pinOut, 16'h2500);

    curReq = "R3";
    wr(8'h14, 16'h0005);
    wr(8'h18, 16'h1000);
    wr(8'h1C, 16'h00F0);
    rd(8'h10, 16'h3550);

    curReq = "R4";
    rd(8'h14, 16'h0000);
    rd(8'h08, 16'h0000);
    rd(8'h70, 16'h0000);
    wr(8'h70, 16'hFFFF);
    wr(8'h12, 16'hFFFF);
    rd(8'h00, 16'h0000);
    rd(8'h10, 16'h3550);

    curReq = "R5";
    wr(8'h20, 16'h1234);
    rd(8'h10, 16'h1234);
    wr(8'h28, 16'h0001);
    rd(8'h10, 16'h1235);

    curReq = "R6";
    pinIn = 16'hFFFF;
    idle(4);
    rd(8'h20, 16'h7F00);
    wr(8'h40, 16'h000F);
    rd(8'h20, 16'h7F0F);

    curReq = "R8";
    wr(8'h60, 16'h0100);
    rd(8'h20, 16'h7F0F);
    pinIn = 16'hFFFE;
    idle(4);
    cmp("irq disabled pin", {15'h0, irq}, 16'h0);
    pinIn = 16'hFEFE;
    idle(4);
    cmp("irq enabled pin", {15'h0, irq}, 16'h1);
    rd(8'h20, 16'h7E0E);
    cmp("irq after pin read", {15'h0, irq}, 16'h0);

    curReq = "R9";
    wr(8'h50, 16'hFFFF);
    cmp("pullUpEn", pullUpEn, 16'h7FFF);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule